// File: doc/BRIEF.md
# Banked Data Register File with Expansion Window

This block holds the general-purpose 8-bit data registers of a small accumulator processor. A register address is a 2-bit bank number and a 5-bit offset. The block turns each address into one physical storage word, into a slot on an external peripheral port, or into nothing. The lower half of the offset range is common to all banks. Its first eight offsets belong to special-function registers that live outside this block, and its other eight offsets reach one set of words whatever bank is selected. The upper half of the offset range is private to each bank. The last four addresses of the last bank do not reach storage. They go to an expansion port that a peripheral circuit answers.

Reads are combinational and writes take effect on the rising clock edge. An instruction can therefore read a register, compute a new value and write it back in the same cycle. With the default parameters the block stores 68 words: 8 shared words plus 4 banks of 16 private words, less the 4 addresses that go to the expansion port.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge, clears every storage word to 0x00.
- R2: When `wr_en` is high at a rising edge and the address maps to storage, the word takes `wdata`. With `rd_en` high, `rdata` shows the stored word of the current address in the same cycle, with no clock edge in between.
- R3: Offsets 0x08 to 0x0F reach the same word in all four banks. A write through any bank can be read back through every other bank.
- R4: Offsets 0x10 to 0x1F of each bank are separate words. A write in one bank leaves the same offset in the other banks unchanged.
- R5: Bank 3 with offsets 0x1C to 0x1F is the expansion window. An access there drives `exp_rd` equal to `rd_en` and `exp_wr` equal to `wr_en`. `exp_addr` is offset bits [1:0] and `exp_wdata` equals `wdata` while `exp_wr` is high. A read returns `exp_rdata`. No storage word changes.
- R6: Outside the expansion window, `exp_rd`, `exp_wr`, `exp_addr` and `exp_wdata` are all 0.
- R7: Offsets 0x00 to 0x07 in every bank belong to outside logic. Writes there change no storage word, and reads return 0x00.
- R8: While `rd_en` is low, `rdata` is 0x00.
- R9: In a cycle with both `rd_en` and `wr_en` high on one storage address, `rdata` shows the old value before the edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bank | input | 2 | Bank number |
| ofs | input | 5 | Offset within the bank |
| rd_en | input | 1 | Read enable |
| wr_en | input | 1 | Write enable |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| exp_rd | output | 1 | Expansion read strobe |
| exp_wr | output | 1 | Expansion write strobe |
| exp_addr | output | 2 | Slot within the expansion window |
| exp_wdata | output | 8 | Expansion write data |
| exp_rdata | input | 8 | Read data returned by the peripheral |

## Verification
The hardest situation to bring about is one where aliasing and isolation both show up in the same stored image. A write through one bank must either reach, or fail to reach, a word that is later read through a different bank. The bench writes a distinct value to every bank and offset in turn, expansion and special-function addresses included. It then reads the whole map back against a model of the requirements. Shared offsets must hold the value of the last bank written. Private offsets must hold their own value. The words next to the expansion window must show that the peripheral writes did not reach storage.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DATA_W    = 8,
  parameter int BANK_W    = 2,
  parameter int OFS_W     = 5,
  parameter int SFR_COUNT = 8,
  parameter int EXP_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              exp_rd,
  output logic              exp_wr,
  output logic [$clog2(EXP_COUNT)-1:0] exp_addr,
  output logic [DATA_W-1:0] exp_wdata,
  input  logic [DATA_W-1:0] exp_rdata
);
  localparam int NBANKS       = 1 << BANK_W;
  localparam int HALF         = 1 << (OFS_W - 1);
  localparam int SHARED_WORDS = HALF - SFR_COUNT;
  localparam int PRIV_WORDS   = NBANKS * HALF;
  localparam int DEPTH        = SHARED_WORDS + PRIV_WORDS - EXP_COUNT;
  localparam int PA_W         = $clog2(DEPTH);
  localparam int LIN_W        = BANK_W + OFS_W - 1;
  localparam int EXP_W        = $clog2(EXP_COUNT);

  logic [DATA_W-1:0] mem [DEPTH];

  logic             is_priv, is_exp, is_sfr, is_store;
  logic [LIN_W-1:0] lin;
  logic [PA_W-1:0]  phys;

  // upper half of the offset range is banked, lower half is common
  assign is_priv  = ofs[OFS_W-1];
  assign lin      = {bank, ofs[OFS_W-2:0]};
  assign is_exp   = is_priv && (lin >= LIN_W'(PRIV_WORDS - EXP_COUNT));
  assign is_sfr   = !is_priv && (ofs[OFS_W-2:0] < (OFS_W-1)'(SFR_COUNT));
  assign is_store = !is_exp && !is_sfr;

  // shared words sit at the bottom of the array, banked words follow
  assign phys = is_priv ? PA_W'(SHARED_WORDS) + PA_W'(lin)
                        : PA_W'(ofs[OFS_W-2:0] - (OFS_W-1)'(SFR_COUNT));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && is_store) begin
      mem[phys] <= wdata;
    end
  end

  assign rdata = !rd_en   ? '0 :
                 is_store ? mem[phys] :
                 is_exp   ? exp_rdata : '0;

  assign exp_rd    = is_exp && rd_en;
  assign exp_wr    = is_exp && wr_en;
  assign exp_addr  = is_exp ? ofs[EXP_W-1:0] : '0;
  assign exp_wdata = exp_wr ? wdata : '0;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DATA_W    = 8,
  parameter int BANK_W    = 2,
  parameter int OFS_W     = 5,
  parameter int SFR_COUNT = 8,
  parameter int EXP_COUNT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [BANK_W-1:0] bank,
  input logic [OFS_W-1:0]  ofs,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              exp_rd,
  input logic              exp_wr,
  input logic [$clog2(EXP_COUNT)-1:0] exp_addr,
  input logic [DATA_W-1:0] exp_wdata,
  input logic [DATA_W-1:0] exp_rdata
);
  localparam int TOP_OFS = (1 << OFS_W) - EXP_COUNT;

  logic in_win, in_sfr, in_store;
  assign in_win   = (bank == '1) && (int'(ofs) >= TOP_OFS);
  assign in_sfr   = int'(ofs) < SFR_COUNT;
  assign in_store = !in_win && !in_sfr;

  // R5
  exp_read_data_chk: assert property (@(posedge clk) disable iff (rst)
    exp_rd |-> (rdata == exp_rdata));

  // R6
  exp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_win |-> (!exp_rd && !exp_wr && exp_addr == '0 && exp_wdata == '0));

  // R7
  sfr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_sfr) |-> (rdata == '0));

  // R8
  rd_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rdata == '0));

  // R2
  write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_store) |=>
      (!(rd_en && bank == $past(bank) && ofs == $past(ofs)) || rdata == $past(wdata)));
endmodule

bind banked_regfile banked_regfile_chk #(
  .DATA_W(DATA_W), .BANK_W(BANK_W), .OFS_W(OFS_W),
  .SFR_COUNT(SFR_COUNT), .EXP_COUNT(EXP_COUNT)
) u_chk (
  .clk(clk), .rst(rst), .bank(bank), .ofs(ofs), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .exp_rd(exp_rd), .exp_wr(exp_wr),
  .exp_addr(exp_addr), .exp_wdata(exp_wdata), .exp_rdata(exp_rdata)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] bank;
  logic [4:0] ofs;
  logic       rd_en, wr_en;
  logic [7:0] wdata, rdata, exp_wdata, exp_rdata;
  logic       exp_rd, exp_wr;
  logic [1:0] exp_addr;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  logic [7:0] model [128];

  always #10 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst), .bank(bank), .ofs(ofs), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .exp_rd(exp_rd), .exp_wr(exp_wr),
    .exp_addr(exp_addr), .exp_wdata(exp_wdata), .exp_rdata(exp_rdata)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (bank %0d ofs %h)", req, act, exp, bank, ofs);
    end
  endtask

  function automatic bit is_win(int b, int o);
    return b == 3 && o >= 28;
  endfunction

  task automatic idle();
    @(negedge clk);
    rd_en = 0; wr_en = 0; wdata = 0;
  endtask

  task automatic wr(int b, int o, logic [7:0] v);
    @(negedge clk);
    bank = 2'(b); ofs = 5'(o); wr_en = 1; rd_en = 0; wdata = v;
    #1;
    if (is_win(b, o)) begin
      chk("R5 exp_wr", {7'b0, exp_wr}, 8'd1);
      chk("R5 exp_addr", {6'b0, exp_addr}, 8'(o & 3));
      chk("R5 exp_wdata", exp_wdata, v);
    end else begin
      chk("R6 strobes", {6'b0, exp_rd, exp_wr}, 8'd0);
      chk("R6 exp_wdata", exp_wdata, 8'd0);
    end
    // model: shared offsets alias, SFR and window touch no storage
    if (o >= 8 && o < 16) for (int k = 0; k < 4; k++) model[k*32+o] = v;
    else if (o >= 16 && !is_win(b, o)) model[b*32+o] = v;
  endtask

  task automatic rd_expect(string req, int b, int o, logic [7:0] exp);
    @(negedge clk);
    bank = 2'(b); ofs = 5'(o); rd_en = 1; wr_en = 0;
    #1;
    chk(req, rdata, exp);
  endtask

  function automatic logic [7:0] expect_of(int b, int o);
    if (o < 8) return 8'h00;
    if (is_win(b, o)) return exp_rdata;
    return model[b*32+o];
  endfunction

  task automatic t_reset_clears();
    @(negedge clk); rst = 1; rd_en = 0; wr_en = 0;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 128; i++) model[i] = 0;
    // R1
    for (int b = 0; b < 4; b++)
      for (int o = 8; o < 32; o++)
        if (!is_win(b, o)) rd_expect("R1 reset value", b, o, 8'h00);
    idle();
  endtask

  task automatic t_fill_and_map();
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 32; o++)
        wr(b, o, 8'((b * 32 + o) ^ 8'h5A));
    idle();
    exp_rdata = 8'hC3;
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 32; o++) begin
        if (o < 8)             rd_expect("R7 sfr read", b, o, expect_of(b, o));
        else if (o < 16)       rd_expect("R3 shared alias", b, o, expect_of(b, o));
        else if (is_win(b, o)) begin
          rd_expect("R5 window read", b, o, expect_of(b, o));
          chk("R5 exp_rd", {7'b0, exp_rd}, 8'd1);
        end else               rd_expect("R4 private word", b, o, expect_of(b, o));
      end
    idle();
  endtask

  task automatic t_private_isolation();
    wr(1, 5'h13, 8'hE7);
    idle();
    rd_expect("R4 own bank", 1, 5'h13, 8'hE7);
    rd_expect("R4 bank0 untouched", 0, 5'h13, model[0*32+19]);
    rd_expect("R4 bank2 untouched", 2, 5'h13, model[2*32+19]);
    wr(2, 5'h0B, 8'h3C);
    idle();
    rd_expect("R3 via bank0", 0, 5'h0B, 8'h3C);
    rd_expect("R3 via bank3", 3, 5'h0B, 8'h3C);
    idle();
  endtask

  task automatic t_rd_disabled();
    @(negedge clk);
    bank = 2'd1; ofs = 5'h13; rd_en = 0; wr_en = 0;
    #1 chk("R8 rdata idle", rdata, 8'h00);
    bank = 2'd3; ofs = 5'h1D;
    #1 chk("R8 window idle", rdata, 8'h00);
    chk("R5 no read strobe", {7'b0, exp_rd}, 8'd0);
    idle();
  endtask

  task automatic t_rmw();
    @(negedge clk);
    bank = 2'd0; ofs = 5'h1E; rd_en = 1; wr_en = 1; wdata = 8'h81;
    #1 chk("R9 old value before edge", rdata, model[30]);
    @(posedge clk); #1;
    chk("R9 new value after edge", rdata, 8'h81);
    chk("R2 same-cycle visibility", rdata, 8'h81);
    model[30] = 8'h81;
    idle();
    rd_expect("R2 held", 0, 5'h1E, 8'h81);
    idle();
  endtask

  task automatic t_sfr_write_ignored();
    wr(2, 5'h03, 8'hFF);
    idle();
    rd_expect("R7 sfr ignored", 2, 5'h03, 8'h00);
    rd_expect("R7 shared intact", 2, 5'h08, model[2*32+8]);
    idle();
  endtask

  initial begin
    rst = 1; bank = 0; ofs = 0; rd_en = 0; wr_en = 0; wdata = 0; exp_rdata = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset_clears();
    t_fill_and_map();
    t_private_isolation();
    t_rd_disabled();
    t_rmw();
    t_sfr_write_ignored();
    t_reset_clears();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule